// File: doc/BRIEF.md
# Interrupt Priority Register File

This block is the software-visible register file of a small nested interrupt controller that serves up to 32 external interrupts. It stores one priority byte per interrupt, a priority-grouping field, a read-only interrupt-count register and a read-only bank of active flags. All of them sit behind a simple 32-bit request/response bus. The arbitration logic next to it reads a per-interrupt group priority from it. That value is the stored priority byte with the subpriority bits cleared by the current grouping setting.

Two parameters shape the block. `PRIO_BITS` sets how many of the eight priority bits exist. Only the top `PRIO_BITS` bits of every priority byte are stored; the rest read as zero and drop writes. `FULL_PROFILE` picks between a full register set and a reduced one. The reduced set turns the interrupt-count register into a reserved, erroring location. It also makes the active bank read as zero and pins the grouping field at zero.

External interrupt 0 is exception number 16, the first slot after the sixteen system exceptions. Active flags are driven by the exception logic through set and clear pulse vectors.

Top module: `irq_prio_regs`

## Requirements
- R1: Each stored priority byte keeps only its upper `PRIO_BITS` bits: the keep mask is `((1<<PRIO_BITS)-1) << (8-PRIO_BITS)` (0xC0 for 2 bits, 0xFF for 8). Masked-off bits read as zero whatever was written.
- R2: Priority bytes are packed four to a word from offset 0x400. Byte lane j (bits 8j+7..8j) of word k belongs to interrupt 4k+j. A write changes only the lanes whose strobe bit j is set.
- R3: Offset 0x004 is read-only in the full profile. It reads ceil(NUM_EXT/32)-1, and writes to it are dropped without error. In the reduced profile any access there returns an error.
- R4: Words at 0x300 to 0x33F are read-only active flags. Bit i of word w is interrupt 32w+i. A set pulse raises a flag and a clear pulse lowers it, and clear wins when both are present. Words beyond the implemented interrupts read zero. In the reduced profile every word reads zero.
- R5: Offset 0xD0C reads 0xFA050000 with the 3-bit grouping field in bits 10..8.
- R6: A write to 0xD0C loads the grouping field from data bits 10..8 only when data bits 31..16 equal 0x05FA and strobes 1, 2 and 3 are all set. Any other write there is discarded. In the reduced profile the field never leaves 0.
- R7: The group-priority output for interrupt i, on bits 8i+7..8i, is its stored byte ANDed with `(0xFF << (g+1))` truncated to 8 bits, where g is the grouping field. g=0 gives 0xFE, g=5 gives 0xC0 and g=7 gives 0x00.
- R8: An access to an offset with no register, to a priority word past the last interrupt, or to an address whose two low bits are not zero returns an error with read data zero. It changes no state.
- R9: Every request gets exactly one response on the following cycle. Write responses carry read data zero.
- R10: After reset all priority bytes, all active flags and the grouping field are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wstrb | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rsp | output | 1 | Response valid, one cycle after the request |
| bus_err | output | 1 | Error response flag |
| bus_rdata | output | 32 | Read data |
| act_set | input | NUM_EXT | Pulses that raise active flags |
| act_clr | input | NUM_EXT | Pulses that lower active flags |
| grp_prio | output | 8*NUM_EXT | Group priority per interrupt, byte i for interrupt i |

## Verification
The bound checker watches several properties on every cycle. It checks the one-cycle request-to-response timing and that error and write responses carry zero data. It checks that no group-priority byte ever shows an unimplemented bit or a bit below the grouping mask. It also checks that the grouping field moves only on a keyed write, and stays zero in the reduced profile. Other properties need a chosen history before they can be seen, so only the bench scenarios show them. These are the lane packing of priority bytes, the exact read-back values and the clear-over-set rule for active flags. The same goes for the reserved interrupt-count location in the reduced profile, side by side with the full one, and for reset clearing state that was written earlier.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  typedef enum logic [2:0] {
    RG_NONE   = 3'd0,
    RG_TYPE   = 3'd1,
    RG_ACTIVE = 3'd2,
    RG_PRIO   = 3'd3,
    RG_CTRL   = 3'd4
  } region_e;

  localparam logic [15:0] CTRL_WR_KEY  = 16'h05FA;
  localparam logic [15:0] CTRL_RD_SIG  = 16'hFA05;
  localparam logic [9:0]  TYPE_WADDR   = 10'h001;
  localparam logic [9:0]  CTRL_WADDR   = 10'h343;
  localparam logic [5:0]  ACTIVE_WPAGE = 6'h0C;
  localparam logic [9:0]  PRIO_WBASE   = 10'h100;

  // Bits of a priority byte that physically exist.
  function automatic logic [7:0] prio_keep_mask(input int unsigned nbits);
    logic [7:0] m;
    m = '0;
    for (int b = 0; b < 8; b++) begin
      if (b >= 8 - int'(nbits)) m[b] = 1'b1;
    end
    return m;
  endfunction

  // Bits of a priority byte that form the group priority for setting g.
  function automatic logic [7:0] group_mask(input logic [2:0] g);
    logic [3:0] sh;
    sh = {1'b0, g} + 4'd1;
    return 8'hFF << sh;
  endfunction

  // Value of the interrupt-count register.
  function automatic logic [31:0] count_code(input int unsigned next);
    return 32'((next + 31) / 32 - 1);
  endfunction

endpackage

// File: rtl/irq_prio_decode.sv
module irq_prio_decode
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_EXT      = 32,
  parameter bit          FULL_PROFILE = 1'b1
) (
  input  logic [11:0] addr,
  output region_e     region,
  output logic [7:0]  word_idx,
  output logic        dec_err
);
  localparam int unsigned PRIO_WORDS = (NUM_EXT + 3) / 4;
  localparam logic [9:0]  PRIO_WEND  = 10'(256 + PRIO_WORDS);

  logic [9:0] waddr;
  logic       aligned;

  assign waddr   = addr[11:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    region   = RG_NONE;
    word_idx = '0;
    if (!aligned) begin
      region = RG_NONE;
    end else if (waddr == TYPE_WADDR) begin
      if (FULL_PROFILE) region = RG_TYPE;
    end else if (waddr[9:4] == ACTIVE_WPAGE) begin
      region   = RG_ACTIVE;
      word_idx = {4'h0, waddr[3:0]};
    end else if (waddr >= PRIO_WBASE && waddr < PRIO_WEND) begin
      region   = RG_PRIO;
      word_idx = 8'(waddr - PRIO_WBASE);
    end else if (waddr == CTRL_WADDR) begin
      region = RG_CTRL;
    end
  end

  assign dec_err = (region == RG_NONE);

endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_EXT   = 32,
  parameter int unsigned PRIO_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [7:0]           word_idx,
  input  logic [3:0]           wstrb,
  input  logic [31:0]          wdata,
  input  logic [2:0]           grp_sel,
  output logic [31:0]          rd_word,
  output logic [NUM_EXT*8-1:0] grp_prio
);
  localparam logic [7:0] KEEP = prio_keep_mask(PRIO_BITS);

  logic [7:0] prio_q [NUM_EXT];
  logic [7:0] gmask;

  assign gmask = group_mask(grp_sel);

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_byte
    localparam int unsigned LANE = i % 4;
    localparam logic [7:0]  WIDX = 8'(i / 4);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[i] <= '0;
      end else if (wr_en && word_idx == WIDX && wstrb[LANE]) begin
        prio_q[i] <= wdata[8*LANE +: 8] & KEEP;
      end
    end
    assign grp_prio[8*i +: 8] = prio_q[i] & gmask;
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < int'(NUM_EXT); i++) begin
      if (word_idx == 8'(i / 4)) rd_word[8*(i%4) +: 8] = prio_q[i];
    end
  end

endmodule

// File: rtl/irq_prio_active.sv
module irq_prio_active #(
  parameter int unsigned NUM_EXT = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] act_set,
  input  logic [NUM_EXT-1:0] act_clr,
  input  logic [3:0]         word_idx,
  output logic [31:0]        rd_word
);
  logic [NUM_EXT-1:0] act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= (act_q | act_set) & ~act_clr;
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < int'(NUM_EXT); i++) begin
      if (word_idx == 4'(i / 32)) rd_word[i % 32] = act_q[i];
    end
  end

endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_EXT      = 32,
  parameter int unsigned PRIO_BITS    = 8,
  parameter bit          FULL_PROFILE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_req,
  input  logic                 bus_wr,
  input  logic [11:0]          bus_addr,
  input  logic [3:0]           bus_wstrb,
  input  logic [31:0]          bus_wdata,
  output logic                 bus_rsp,
  output logic                 bus_err,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_EXT-1:0]   act_set,
  input  logic [NUM_EXT-1:0]   act_clr,
  output logic [NUM_EXT*8-1:0] grp_prio
);
  localparam logic [31:0] COUNT_VAL = count_code(NUM_EXT);

  region_e     region;
  logic [7:0]  word_idx;
  logic        dec_err;
  logic        wr_fire;
  logic        prio_wr;
  logic        ctrl_key_ok;
  logic        grp_write_ok;
  logic [2:0]  grp_q;
  logic [31:0] prio_rd;
  logic [31:0] act_rd;
  logic [31:0] rd_mux;

  irq_prio_decode #(
    .NUM_EXT      (NUM_EXT),
    .FULL_PROFILE (FULL_PROFILE)
  ) u_decode (
    .addr     (bus_addr),
    .region   (region),
    .word_idx (word_idx),
    .dec_err  (dec_err)
  );

  assign wr_fire      = bus_req && bus_wr && !dec_err;
  assign prio_wr      = wr_fire && (region == RG_PRIO);
  assign ctrl_key_ok  = (bus_wdata[31:16] == CTRL_WR_KEY) && (&bus_wstrb[3:1]);
  assign grp_write_ok = FULL_PROFILE && wr_fire && (region == RG_CTRL) && ctrl_key_ok;

  if (FULL_PROFILE) begin : g_grp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            grp_q <= '0;
      else if (grp_write_ok) grp_q <= bus_wdata[10:8];
    end
  end else begin : g_grp_fixed
    assign grp_q = '0;
  end

  irq_prio_bank #(
    .NUM_EXT   (NUM_EXT),
    .PRIO_BITS (PRIO_BITS)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (prio_wr),
    .word_idx (word_idx),
    .wstrb    (bus_wstrb),
    .wdata    (bus_wdata),
    .grp_sel  (grp_q),
    .rd_word  (prio_rd),
    .grp_prio (grp_prio)
  );

  if (FULL_PROFILE) begin : g_act
    irq_prio_active #(
      .NUM_EXT (NUM_EXT)
    ) u_active (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_set  (act_set),
      .act_clr  (act_clr),
      .word_idx (word_idx[3:0]),
      .rd_word  (act_rd)
    );
  end else begin : g_act_none
    assign act_rd = '0;
  end

  always_comb begin
    unique case (region)
      RG_TYPE:   rd_mux = COUNT_VAL;
      RG_ACTIVE: rd_mux = act_rd;
      RG_PRIO:   rd_mux = prio_rd;
      RG_CTRL:   rd_mux = {CTRL_RD_SIG, 5'b0, grp_q, 8'h00};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rsp   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_rsp   <= bus_req;
      bus_err   <= bus_req && dec_err;
      bus_rdata <= (bus_req && !bus_wr && !dec_err) ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/irq_prio_regs_sva.sv
module irq_prio_regs_sva
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_EXT      = 32,
  parameter int unsigned PRIO_BITS    = 8,
  parameter bit          FULL_PROFILE = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_req,
  input logic                 bus_wr,
  input logic [11:0]          bus_addr,
  input logic                 bus_rsp,
  input logic                 bus_err,
  input logic [31:0]          bus_rdata,
  input logic [NUM_EXT*8-1:0] grp_prio,
  input logic [2:0]           grp_q,
  input logic                 grp_write_ok
);
  localparam logic [7:0] KEEP = prio_keep_mask(PRIO_BITS);

  logic [7:0] stray_low;
  logic [7:0] stray_sub;

  always_comb begin
    stray_low = '0;
    stray_sub = '0;
    for (int i = 0; i < int'(NUM_EXT); i++) begin
      stray_low = stray_low | (grp_prio[8*i +: 8] & ~KEEP);
      stray_sub = stray_sub | (grp_prio[8*i +: 8] & ~group_mask(grp_q));
    end
  end

  assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_rsp);
  assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !bus_rsp);
  assert_write_rdata_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr) |=> (bus_rdata == 32'h0));
  assert_err_rdata_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rsp && bus_err) |-> (bus_rdata == 32'h0));
  assert_unimpl_bits_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stray_low == 8'h00);
  assert_group_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stray_sub == 8'h00);
  assert_grp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_write_ok |=> $stable(grp_q));
  assert_grp_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (FULL_PROFILE || grp_q == 3'd0));
  assert_count_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!FULL_PROFILE && bus_req && bus_addr == 12'h004) |=> bus_err);

endmodule

bind irq_prio_regs irq_prio_regs_sva #(
  .NUM_EXT      (NUM_EXT),
  .PRIO_BITS    (PRIO_BITS),
  .FULL_PROFILE (FULL_PROFILE)
) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_req      (bus_req),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_rsp      (bus_rsp),
  .bus_err      (bus_err),
  .bus_rdata    (bus_rdata),
  .grp_prio     (grp_prio),
  .grp_q        (grp_q),
  .grp_write_ok (grp_write_ok)
);

// File: tb/irq_prio_regs_bench.sv
`timescale 1ns/1ps
module irq_prio_regs_bench;
  localparam int unsigned NEXT = 32;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [3:0]  strb;
    logic [31:0] wdata;
    logic [31:0] f_rd;
    logic        f_err;
    logic [31:0] l_rd;
    logic        l_err;
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 12'h004, 4'h0, 32'h0,        32'h0,        1'b0, 32'h0,        1'b1}, // R3
    '{1'b1, 12'h400, 4'hF, 32'h12345678, 32'h0,        1'b0, 32'h0,        1'b0}, // R2
    '{1'b0, 12'h400, 4'h0, 32'h0,        32'h12345678, 1'b0, 32'h00004040, 1'b0}, // R1 R2
    '{1'b1, 12'h404, 4'h5, 32'hFFFFFFFF, 32'h0,        1'b0, 32'h0,        1'b0}, // R2
    '{1'b0, 12'h404, 4'h0, 32'h0,        32'h00FF00FF, 1'b0, 32'h00C000C0, 1'b0}, // R2
    '{1'b1, 12'h41C, 4'h8, 32'hAB000000, 32'h0,        1'b0, 32'h0,        1'b0}, // R2
    '{1'b0, 12'h41C, 4'h0, 32'h0,        32'hAB000000, 1'b0, 32'h80000000, 1'b0}, // R1
    '{1'b0, 12'hD0C, 4'h0, 32'h0,        32'hFA050000, 1'b0, 32'hFA050000, 1'b0}, // R5
    '{1'b1, 12'hD0C, 4'hF, 32'h05FA0300, 32'h0,        1'b0, 32'h0,        1'b0}, // R6
    '{1'b0, 12'hD0C, 4'h0, 32'h0,        32'hFA050300, 1'b0, 32'hFA050000, 1'b0}, // R5 R6
    '{1'b1, 12'hD0C, 4'hF, 32'h12340500, 32'h0,        1'b0, 32'h0,        1'b0}, // R6
    '{1'b0, 12'hD0C, 4'h0, 32'h0,        32'hFA050300, 1'b0, 32'hFA050000, 1'b0}, // R6
    '{1'b1, 12'hD0C, 4'h3, 32'h05FA0500, 32'h0,        1'b0, 32'h0,        1'b0}, // R6
    '{1'b0, 12'hD0C, 4'h0, 32'h0,        32'hFA050300, 1'b0, 32'hFA050000, 1'b0}, // R6
    '{1'b0, 12'h300, 4'h0, 32'h0,        32'h0,        1'b0, 32'h0,        1'b0}, // R4
    '{1'b0, 12'h420, 4'h0, 32'h0,        32'h0,        1'b1, 32'h0,        1'b1}, // R8
    '{1'b0, 12'h008, 4'h0, 32'h0,        32'h0,        1'b1, 32'h0,        1'b1}, // R8
    '{1'b1, 12'h401, 4'hF, 32'hFFFFFFFF, 32'h0,        1'b1, 32'h0,        1'b1}, // R8
    '{1'b1, 12'h004, 4'hF, 32'hFFFFFFFF, 32'h0,        1'b0, 32'h0,        1'b1}, // R3
    '{1'b0, 12'h004, 4'h0, 32'h0,        32'h0,        1'b0, 32'h0,        1'b1}, // R3
    '{1'b0, 12'h400, 4'h0, 32'h0,        32'h12345678, 1'b0, 32'h00004040, 1'b0}  // R8
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [3:0]  bus_wstrb = '0;
  logic [31:0] bus_wdata = '0;
  logic [NEXT-1:0] act_set = '0, act_clr = '0;
  logic f_rsp, f_err, l_rsp, l_err;
  logic [31:0] f_rd, l_rd;
  logic [NEXT*8-1:0] f_grp, l_grp;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_prio_regs #(.NUM_EXT(NEXT), .PRIO_BITS(8), .FULL_PROFILE(1'b1)) u_irq_prio_regs (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata), .bus_rsp(f_rsp), .bus_err(f_err),
    .bus_rdata(f_rd), .act_set(act_set), .act_clr(act_clr), .grp_prio(f_grp));

  irq_prio_regs #(.NUM_EXT(NEXT), .PRIO_BITS(2), .FULL_PROFILE(1'b0)) u_irq_prio_regs_lite (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata), .bus_rsp(l_rsp), .bus_err(l_err),
    .bus_rdata(l_rd), .act_set(act_set), .act_clr(act_clr), .grp_prio(l_grp));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // One access on both instances; the response is sampled at the next falling edge.
  task automatic access(input logic wr, input logic [11:0] addr, input logic [3:0] strb,
                        input logic [31:0] data,
                        output logic [31:0] frd, output logic ferr,
                        output logic [31:0] lrd, output logic lerr);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = wr; bus_addr = addr; bus_wstrb = strb; bus_wdata = data;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
    check("R9 full rsp", {31'b0, f_rsp}, 32'd1);
    check("R9 lite rsp", {31'b0, l_rsp}, 32'd1);
    frd = f_rd; ferr = f_err; lrd = l_rd; lerr = l_err;
  endtask

  task automatic rd_full(input string req, input logic [11:0] addr, input logic [31:0] exp);
    logic [31:0] a, b; logic ea, eb;
    access(1'b0, addr, 4'h0, 32'h0, a, ea, b, eb);
    check(req, a, exp);
    check(req, {31'b0, ea}, 32'd0);
  endtask

  task automatic wr_both(input logic [11:0] addr, input logic [31:0] data);
    logic [31:0] a, b; logic ea, eb;
    access(1'b1, addr, 4'hF, data, a, ea, b, eb);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [31:0] a, b; logic ea, eb;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 full grp out", {31'b0, |f_grp}, 32'd0);
    check("R10 lite grp out", {31'b0, |l_grp}, 32'd0);
    check("R9 idle no rsp", {30'b0, f_rsp, l_rsp}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_full("R10 prio after reset", 12'h400, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      access(VECS[v].wr, VECS[v].addr, VECS[v].strb, VECS[v].wdata, a, ea, b, eb);
      check($sformatf("vec%0d full rdata", v), a, VECS[v].f_rd);
      check($sformatf("vec%0d full err", v), {31'b0, ea}, {31'b0, VECS[v].f_err});
      check($sformatf("vec%0d lite rdata", v), b, VECS[v].l_rd);
      check($sformatf("vec%0d lite err", v), {31'b0, eb}, {31'b0, VECS[v].l_err});
    end

    // R7: grouping 3 in full (mask F0), 0 in lite (mask FE)
    check("R7 full irq0 g3", {24'b0, f_grp[7:0]}, 32'h70);
    check("R7 full irq4 g3", {24'b0, f_grp[39:32]}, 32'hF0);
    check("R7 full irq31 g3", {24'b0, f_grp[255:248]}, 32'hA0);
    check("R7 lite irq0", {24'b0, l_grp[7:0]}, 32'h40);
    check("R7 lite irq31", {24'b0, l_grp[255:248]}, 32'h80);
    check("R1 lite irq2", {24'b0, l_grp[23:16]}, 32'h00);

    wr_both(12'hD0C, 32'h05FA0700);
    rd_full("R5 grouping 7", 12'hD0C, 32'hFA050700);
    check("R7 full irq4 g7", {24'b0, f_grp[39:32]}, 32'h00);
    check("R6 lite frozen", {24'b0, l_grp[39:32]}, 32'hC0);
    wr_both(12'hD0C, 32'h05FA0000);
    check("R7 full irq4 g0", {24'b0, f_grp[39:32]}, 32'hFE);
    check("R7 full irq1 g0", {24'b0, f_grp[15:8]}, 32'h56);
    wr_both(12'hD0C, 32'h05FA0500);
    check("R7 full irq0 g5", {24'b0, f_grp[7:0]}, 32'h40);

    // R4: active flags
    @(negedge clk);
    act_set = 32'h80000021;
    @(negedge clk);
    act_set = '0;
    access(1'b0, 12'h300, 4'h0, 32'h0, a, ea, b, eb);
    check("R4 full active", a, 32'h80000021);
    check("R4 lite active zero", b, 32'h0);
    @(negedge clk);
    act_set = 32'h00000020; act_clr = 32'h00000021;
    @(negedge clk);
    act_set = '0; act_clr = '0;
    rd_full("R4 clear wins", 12'h300, 32'h80000000);
    rd_full("R4 unimplemented word", 12'h304, 32'h0);

    // R10: reset again after state was written
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R10 grp out cleared", {31'b0, |f_grp}, 32'd0);
    rd_full("R10 prio cleared", 12'h41C, 32'h0);
    rd_full("R10 grouping cleared", 12'hD0C, 32'hFA050000);
    rd_full("R10 active cleared", 12'h300, 32'h0);

    finish_run();
  end

endmodule